// File: doc/BRIEF.md
# Keypad Sequence Combination Lock

This block watches a row of ten push-buttons and raises a single open signal once a fixed eight-digit combination has been keyed in. Each button stands for one decimal digit. The block receives the buttons as a vector in which a digit is shown by its own bit alone being high. A press can last for any number of clock cycles. Every press has to be released, so that the whole vector reads zero again, before the next digit is taken.

The combination is 1, 0, 0, 8, 4, 8, 6, 9. It is a parameter of the block. A press that does not match the expected digit sends the block back to the start. Any press with more than one button down counts as a wrong press. After a wrong press the user must release the buttons and enter the combination again from its first digit. Once open, the block stays open until reset. The buttons are plain control inputs sampled on the rising edge, with no handshake. They are expected to arrive already synchronised and debounced.

Top module: `keypad_lock`

## Requirements
- R1: Digit N is entered by driving bit N of `keys` high with all other bits low. Bit 0 is digit 0 and bit 9 is digit 9. The binary value of the vector plays no part.
- R2: The combination is the digit sequence 1, 0, 0, 8, 4, 8, 6, 9. `unlock` goes high on the rising edge that samples the correct eighth press, so it is visible one cycle after that press is first applied.
- R3: After an accepted press, any non-zero value on `keys` is ignored until a cycle with `keys` all zero has been sampled. A direct change from one button to another without a release counts as a single press.
- R4: A press held for several cycles advances the sequence by exactly one digit.
- R5: A single-button press that is not the expected digit returns the block to the start of the combination. The block then waits for a release, and that press is not reused as a first digit.
- R6: A press with two or more bits of `keys` high is treated as a wrong press and returns the block to the start.
- R7: Once `unlock` is high it stays high, and no button activity changes it, until reset.
- R8: `rst` is synchronous and wins over button evaluation in the same cycle. It clears `unlock` and all progress through the combination.
- R9: `unlock` stays low until all eight digits have been accepted in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| keys | input | NUM_KEYS (10) | Button vector; one high bit marks the pressed digit |
| unlock | output | 1 | High once the full combination has been accepted |

## Verification
For every position in the combination, the bench sweeps every wrong single digit and a two-button press. It checks that the lock stays shut and that a fresh full entry still opens it, which separates a true restart from a stuck or skipped state. Presses and releases held for varied lengths check that a held press counts once. Button-to-button changes without a release show whether a release is really required. A wrong digit equal to the first code digit shows whether a rejected press is wrongly reused. Resets are applied mid-entry, while open, and together with a valid first press, which checks both clearing and priority.

// File: rtl/keypad_lock_pkg.sv
package keypad_lock_pkg;

  // Tracker states
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,  // waiting for the next digit press
    ST_HELD   = 2'd1,  // accepted press still down, waiting for release
    ST_REJECT = 2'd2,  // wrong press seen, waiting for release
    ST_OPEN   = 2'd3   // combination complete
  } lock_state_e;

endpackage

// File: rtl/key_decoder.sv
module key_decoder #(
  parameter int NUM_KEYS = 10,
  parameter int DIG_W    = $clog2(NUM_KEYS)
) (
  input  logic [NUM_KEYS-1:0] keys,
  output logic                idle,
  output logic                single,
  output logic [DIG_W-1:0]    digit
);

  localparam int CNT_W = $clog2(NUM_KEYS + 1);

  logic [CNT_W-1:0] hits;

  always_comb begin
    hits  = '0;
    digit = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (keys[i]) begin
        hits  = hits + CNT_W'(1);
        digit = DIG_W'(i);
      end
    end
  end

  assign idle   = (hits == '0);
  assign single = (hits == CNT_W'(1));

  always_comb begin
    if (single === 1'b1) begin
      AST_DIGIT_IS_PRESSED_KEY: assert (keys[digit] == 1'b1); // R1
    end
  end

endmodule

// File: rtl/code_table.sv
module code_table #(
  parameter int                        CODE_LEN = 8,
  parameter int                        DIG_W    = 4,
  parameter int                        IDX_W    = 3,
  parameter logic [CODE_LEN*DIG_W-1:0] CODE     = 32'h96848001
) (
  input  logic [IDX_W-1:0] idx,
  output logic [DIG_W-1:0] expected,
  output logic             last
);

  logic [DIG_W-1:0] entry [CODE_LEN];

  for (genvar g = 0; g < CODE_LEN; g++) begin : g_entry
    assign entry[g] = CODE[g*DIG_W +: DIG_W];
  end

  assign expected = entry[idx];
  assign last     = (idx == IDX_W'(CODE_LEN - 1));

endmodule

// File: rtl/seq_tracker.sv
module seq_tracker
  import keypad_lock_pkg::*;
#(
  parameter int DIG_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic             single,
  input  logic [DIG_W-1:0] digit,
  input  logic [DIG_W-1:0] expected,
  input  logic             last,
  output logic [IDX_W-1:0] idx,
  output logic             unlock
);

  lock_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ARMED;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (!idle) begin
            if (single && (digit == expected)) begin
              state <= last ? ST_OPEN : ST_HELD;
            end else begin
              state <= ST_REJECT;
              idx   <= '0;
            end
          end
        end
        ST_HELD: begin
          if (idle) begin
            state <= ST_ARMED;
            idx   <= idx + IDX_W'(1);
          end
        end
        ST_REJECT: begin
          if (idle) state <= ST_ARMED;
        end
        ST_OPEN: state <= ST_OPEN;
        default: state <= ST_ARMED;
      endcase
    end
  end

  assign unlock = (state == ST_OPEN);

  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    unlock |=> unlock); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!unlock && idx == '0)); // R8

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (idx == $past(idx) || idx == $past(idx) + IDX_W'(1) || idx == '0)); // R4

  AST_ADVANCE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (idx != '0 && idx != $past(idx)) |-> $past(idle)); // R3

  AST_MULTI_REJECT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && !idle && !single) |=> (state == ST_REJECT)); // R6

  AST_OPEN_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> ($past(last) && $past(single) && $past(digit) == $past(expected))); // R2

endmodule

// File: rtl/keypad_lock.sv
module keypad_lock #(
  parameter int                        NUM_KEYS = 10,
  parameter int                        CODE_LEN = 8,
  parameter int                        DIG_W    = $clog2(NUM_KEYS),
  parameter logic [CODE_LEN*DIG_W-1:0] CODE     = 32'h96848001
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keys,
  output logic                unlock
);

  localparam int IDX_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;

  logic             idle;
  logic             single;
  logic [DIG_W-1:0] digit;
  logic [DIG_W-1:0] expected;
  logic             last;
  logic [IDX_W-1:0] idx;

  key_decoder #(
    .NUM_KEYS (NUM_KEYS),
    .DIG_W    (DIG_W)
  ) decode_i (
    .keys   (keys),
    .idle   (idle),
    .single (single),
    .digit  (digit)
  );

  code_table #(
    .CODE_LEN (CODE_LEN),
    .DIG_W    (DIG_W),
    .IDX_W    (IDX_W),
    .CODE     (CODE)
  ) table_i (
    .idx      (idx),
    .expected (expected),
    .last     (last)
  );

  seq_tracker #(
    .DIG_W (DIG_W),
    .IDX_W (IDX_W)
  ) track_i (
    .clk      (clk),
    .rst      (rst),
    .idle     (idle),
    .single   (single),
    .digit    (digit),
    .expected (expected),
    .last     (last),
    .idx      (idx),
    .unlock   (unlock)
  );

endmodule

// File: tb/keypad_lock_tb_top.sv
module keypad_lock_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] keys = '0;
  logic       unlock;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int code [8] = '{1, 0, 0, 8, 4, 8, 6, 9};

  always #5 clk = ~clk;

  keypad_lock dut_i (
    .clk    (clk),
    .rst    (rst),
    .keys   (keys),
    .unlock (unlock)
  );

  function automatic logic [9:0] key(input int d);
    return 10'(1) << d;
  endfunction

  task automatic check(input logic exp, input string req, input string what);
    checks++;
    if (unlock !== exp) begin
      errors++;
      $display("FAIL %s %s: unlock=%b expected=%b", req, what, unlock, exp);
    end
  endtask

  // Apply one cycle of inputs; sample 2 ns after the edge that registers them.
  task automatic step(input logic [9:0] v, input logic r);
    @(negedge clk);
    keys = v;
    rst  = r;
    @(posedge clk);
    #2;
  endtask

  task automatic press(input int d, input int hold, input int rel);
    for (int h = 0; h < hold; h++) step(key(d), 1'b0);
    for (int h = 0; h < rel; h++) step('0, 1'b0);
  endtask

  task automatic enter(input int from, input int upto);
    for (int i = from; i <= upto; i++) press(code[i], 1, 1);
  endtask

  task automatic do_reset();
    step('0, 1'b1);
    step('0, 1'b1);
    step('0, 1'b0);
  endtask

  initial begin
    do_reset();
    check(1'b0, "R8", "after reset");

    // R1 R2 R9: plain entry, open exactly on eighth press
    enter(0, 6);
    check(1'b0, "R9", "seven digits entered");
    step(key(code[7]), 1'b0);
    check(1'b1, "R2", "open after eighth press");
    check(1'b1, "R1", "one-hot digits decoded");

    // R7: buttons after opening have no effect
    for (int i = 0; i < 20; i++) begin
      step((i % 3 == 0) ? 10'h3FF : key(i % 10), 1'b0);
      check(1'b1, "R7", "sticky open under presses");
    end

    // R8: reset while open
    step('0, 1'b1);
    check(1'b0, "R8", "reset while open");
    step('0, 1'b0);

    // R4: long holds and long releases
    for (int i = 0; i < 8; i++) press(code[i], 1 + (i % 4), 1 + (i % 3));
    check(1'b1, "R4", "held presses counted once");

    // R3: two code zeros entered as one long hold do not count twice
    do_reset();
    press(1, 1, 1);
    press(0, 4, 1);
    enter(3, 7);
    check(1'b0, "R3", "missing release between repeated digit");

    // R3: change of button without release is one press
    do_reset();
    step(key(1), 1'b0);
    step(key(0), 1'b0);
    step('0, 1'b0);
    enter(2, 7);
    check(1'b0, "R3", "button change without release");

    // R5: rejected press equal to first digit is not reused
    do_reset();
    enter(0, 2);
    press(1, 1, 1);
    enter(1, 7);
    check(1'b0, "R5", "wrong press not reused as first digit");

    // R5 R6 sweep over every position and every wrong press
    for (int k = 0; k < 8; k++) begin
      for (int d = 0; d < 10; d++) begin
        if (d != code[k]) begin
          do_reset();
          if (k > 0) enter(0, k - 1);
          press(d, 2, 1);
          check(1'b0, "R5", $sformatf("wrong digit %0d at position %0d", d, k));
          enter(0, 7);
          check(1'b1, "R5", $sformatf("restart after digit %0d at position %0d", d, k));
        end
      end
      do_reset();
      if (k > 0) enter(0, k - 1);
      step(key(code[k]) | key((code[k] + 1) % 10), 1'b0);
      step('0, 1'b0);
      if (k < 7) enter(k + 1, 7);
      check(1'b0, "R6", $sformatf("two buttons at position %0d", k));
      enter(0, 7);
      check(1'b1, "R6", $sformatf("restart after two buttons at position %0d", k));
    end

    // R8: reset mid-entry clears progress
    do_reset();
    enter(0, 3);
    step('0, 1'b1);
    step('0, 1'b0);
    enter(4, 7);
    check(1'b0, "R8", "progress cleared by reset");

    // R8: reset wins over a valid first press in the same cycle
    do_reset();
    step(key(code[0]), 1'b1);
    step('0, 1'b0);
    enter(1, 7);
    check(1'b0, "R8", "press during reset ignored");
    enter(0, 7);
    check(1'b1, "R8", "full code after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule